// File: doc/BRIEF.md
# SDRAM Read Data Latency Pipeline

This block lies between the read path of a synchronous DRAM style array and the host side of a 16-bit data bus. A read strobe starts a burst of a fixed number of words. The block takes one array word per burst cycle and delays it by a programmable read latency of one, two or three clocks. It then drives the word with a drive enable for each byte and a valid flag. This reproduces the output timing that a 16-bit synchronous DRAM shows on its pins.

Each byte has its own read mask bit. The block samples the mask every cycle, and the mask shuts off that byte's drive two clocks later. A burst-stop strobe ends the data stream after the programmed latency. A precharge strobe ends it at a fixed three clocks. A new read strobe may cut into a running burst on any cycle. The latency setting is taken only while nothing is in flight.

Top module: `sdram_rdlat_pipe`

## Requirements
- R1: After reset, `dq_o`, `drv_en_o` and `vld_o` are all zero and the latency in use is 2 clocks. A `lat_cfg_i` of 0 leaves it at 2.
- R2: A word presented on `arr_data_i` in an active burst cycle t appears on `dq_o` in cycle t+L, where L is the latency in use. L is 1, 2 or 3 and is set by `lat_cfg_i` values 1, 2 and 3.
- R3: A read strobe in cycle t makes cycles t to t+3 active burst cycles (burst length 4). The outputs show words in cycles t+L to t+L+3, and each word is the array data sampled in its own burst cycle.
- R4: A read strobe during a running burst restarts the count of 4 at once, on any cycle. The words continue with no gap.
- R5: `rmask_i` bit 0 covers `dq_o[7:0]` and bit 1 covers `dq_o[15:8]`. A mask bit sampled in cycle t clears that byte's `drv_en_o` bit and forces the byte to zero in cycle t+2. This does not depend on when the read was issued.
- R6: `vld_o` is 1 exactly in cycles where a burst word is output and at least one byte is enabled. With no word, `drv_en_o` and `dq_o` are zero.
- R7: A burst-stop strobe in cycle t makes cycle t and all later cycles inactive, until the next read strobe after cycle t. No word appears from cycle t+L on. A stop in the same cycle as a read strobe suppresses that read.
- R8: A precharge strobe in cycle t means that no word of the current burst appears in cycle t+3 or later. This includes a read strobed in cycle t.
- R9: A `lat_cfg_i` value from 1 to 3 is loaded as the latency only in a cycle with no burst cycles remaining, no word in the delay stages and no pending precharge. Values given while busy, and the value 0, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_issue_i | input | 1 | Read strobe, starts a burst |
| lat_cfg_i | input | 2 | Requested read latency (1 to 3, 0 = keep) |
| rmask_i | input | 2 | Read byte mask, bit 1 upper byte |
| stop_i | input | 1 | Burst-stop strobe |
| pre_i | input | 1 | Precharge strobe |
| arr_data_i | input | 16 | Array word for the current burst cycle |
| dq_o | output | 16 | Output data, masked bytes zero |
| drv_en_o | output | 2 | Per-byte output drive enable |
| vld_o | output | 1 | Word valid flag |

## Verification
The bench uses the default parameters: 16-bit data, maximum latency 3, burst length 4, precharge cut-off 3 and mask delay 2. With these values every latency can be reached. They also include the case where a precharge kills the burst at once (latency 3) and the cases where it lets one or two more words out (latencies 2 and 1). Because the burst is four words long, a restart, a stop or a mask change can land in the middle of a burst. A reference model with history arrays predicts every cycle. It covers interrupted bursts, stops and precharges at each latency, and latency requests made while busy.

// File: rtl/sdrl_pkg.sv
package sdrl_pkg;
   // legal latency code: 1..max
   function automatic logic lat_legal(input int v, input int maxl);
      return (v >= 1) && (v <= maxl);
   endfunction
endpackage

// File: rtl/sdrl_burst_ctl.sv
module sdrl_burst_ctl #(
   parameter int BURST_LEN = 4,
   parameter int PRE_HIZ   = 3,
   parameter int LAT_W     = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rd_issue_i,
   input  logic             stop_i,
   input  logic             pre_i,
   input  logic [LAT_W-1:0] lat_i,
   output logic             word_act_o,
   output logic             busy_o
);
   localparam int PC_W = $clog2(PRE_HIZ + 1);

   logic [PC_W-1:0] pc_q;
   logic            kill;
   logic            rem_busy;

   // stop now, precharge at latency==cut-off now, or a pending precharge expiring
   assign kill = stop_i | (pre_i & (int'(lat_i) >= PRE_HIZ)) | (pc_q == PC_W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) pc_q <= '0;
      else if (pre_i && (int'(lat_i) < PRE_HIZ)) pc_q <= PC_W'(PRE_HIZ - int'(lat_i));
      else if (pc_q != '0) pc_q <= pc_q - PC_W'(1);
   end

   generate
      if (BURST_LEN == 1) begin : g_single
         assign word_act_o = rd_issue_i & ~kill;
         assign rem_busy   = 1'b0;
      end else begin : g_multi
         localparam int RW = $clog2(BURST_LEN);
         logic [RW-1:0] rem_q;
         assign word_act_o = (rd_issue_i | (rem_q != '0)) & ~kill;
         assign rem_busy   = (rem_q != '0);
         always_ff @(posedge clk) begin
            if (!rst_n || kill) rem_q <= '0;
            else if (rd_issue_i) rem_q <= RW'(BURST_LEN - 1);
            else if (rem_q != '0) rem_q <= rem_q - RW'(1);
         end
      end
   endgenerate

   assign busy_o = rem_busy | (pc_q != '0);

   AST_STOP_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
      stop_i |=> (!word_act_o || rd_issue_i)); // R7
endmodule

// File: rtl/sdrl_lat_pipe.sv
module sdrl_lat_pipe #(
   parameter int DATA_W  = 16,
   parameter int MAX_LAT = 3,
   parameter int LAT_W   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              act_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic [LAT_W-1:0]  lat_i,
   output logic              act_o,
   output logic [DATA_W-1:0] data_o,
   output logic              busy_o
);
   logic [MAX_LAT-1:0] st_act;
   logic [DATA_W-1:0]  st_dat [MAX_LAT];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_act[0] <= 1'b0;
         st_dat[0] <= '0;
      end else begin
         st_act[0] <= act_i;
         st_dat[0] <= act_i ? data_i : '0;
      end
   end

   generate
      for (genvar k = 1; k < MAX_LAT; k++) begin : g_stage
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               st_act[k] <= 1'b0;
               st_dat[k] <= '0;
            end else begin
               st_act[k] <= st_act[k-1];
               st_dat[k] <= st_dat[k-1];
            end
         end
      end
   endgenerate

   // tap selected by latency: stage k holds the word from k+1 cycles ago
   always_comb begin
      act_o  = 1'b0;
      data_o = '0;
      for (int k = 0; k < MAX_LAT; k++) begin
         if (int'(lat_i) == k + 1) begin
            act_o  = st_act[k];
            data_o = st_dat[k];
         end
      end
   end

   assign busy_o = |st_act;

   AST_LAT1_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(lat_i) == 1 && $stable(lat_i)) |-> (act_o == $past(act_i))); // R2
endmodule

// File: rtl/sdrl_mask_pipe.sv
module sdrl_mask_pipe #(
   parameter int BYTES    = 2,
   parameter int MASK_LAT = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [BYTES-1:0] mask_i,
   output logic [BYTES-1:0] mask_o
);
   generate
      if (MASK_LAT == 0) begin : g_direct
         assign mask_o = mask_i;
      end else begin : g_delay
         logic [BYTES-1:0] sh [MASK_LAT];
         for (genvar k = 0; k < MASK_LAT; k++) begin : g_sh
            always_ff @(posedge clk) begin
               if (!rst_n) sh[k] <= '0;
               else        sh[k] <= (k == 0) ? mask_i : sh[(k == 0) ? 0 : k-1];
            end
         end
         assign mask_o = sh[MASK_LAT-1];
      end
   endgenerate
endmodule

// File: rtl/sdram_rdlat_pipe.sv
module sdram_rdlat_pipe #(
   parameter int DATA_W    = 16,
   parameter int MAX_LAT   = 3,
   parameter int DEF_LAT   = 2,
   parameter int BURST_LEN = 4,
   parameter int PRE_HIZ   = 3,
   parameter int MASK_LAT  = 2
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           rd_issue_i,
   input  logic [$clog2(MAX_LAT+1)-1:0]   lat_cfg_i,
   input  logic [DATA_W/8-1:0]            rmask_i,
   input  logic                           stop_i,
   input  logic                           pre_i,
   input  logic [DATA_W-1:0]              arr_data_i,
   output logic [DATA_W-1:0]              dq_o,
   output logic [DATA_W/8-1:0]            drv_en_o,
   output logic                           vld_o
);
   import sdrl_pkg::*;

   localparam int BYTES = DATA_W / 8;
   localparam int LAT_W = $clog2(MAX_LAT + 1);

   generate
      if (DATA_W % 8 != 0) begin : g_bad_width
         $error("DATA_W must be a whole number of bytes");
      end
      if (DEF_LAT < 1 || DEF_LAT > MAX_LAT) begin : g_bad_def
         $error("DEF_LAT outside 1..MAX_LAT");
      end
      if (PRE_HIZ < MAX_LAT) begin : g_bad_pre
         $error("PRE_HIZ must not be below MAX_LAT");
      end
      if (BURST_LEN < 1) begin : g_bad_bl
         $error("BURST_LEN must be at least 1");
      end
   endgenerate

   logic [LAT_W-1:0]  lat_q;
   logic              word_act, burst_busy, pipe_busy, busy;
   logic              act_out;
   logic [DATA_W-1:0] data_out;
   logic [BYTES-1:0]  mask_d;

   sdrl_burst_ctl #(.BURST_LEN(BURST_LEN), .PRE_HIZ(PRE_HIZ), .LAT_W(LAT_W)) u_burst (
      .clk(clk), .rst_n(rst_n), .rd_issue_i(rd_issue_i), .stop_i(stop_i), .pre_i(pre_i),
      .lat_i(lat_q), .word_act_o(word_act), .busy_o(burst_busy));

   sdrl_lat_pipe #(.DATA_W(DATA_W), .MAX_LAT(MAX_LAT), .LAT_W(LAT_W)) u_pipe (
      .clk(clk), .rst_n(rst_n), .act_i(word_act), .data_i(arr_data_i), .lat_i(lat_q),
      .act_o(act_out), .data_o(data_out), .busy_o(pipe_busy));

   sdrl_mask_pipe #(.BYTES(BYTES), .MASK_LAT(MASK_LAT)) u_mask (
      .clk(clk), .rst_n(rst_n), .mask_i(rmask_i), .mask_o(mask_d));

   assign busy = burst_busy | pipe_busy;

   always_ff @(posedge clk) begin
      if (!rst_n) lat_q <= LAT_W'(DEF_LAT);
      else if (!busy && lat_legal(int'(lat_cfg_i), MAX_LAT)) lat_q <= lat_cfg_i;
   end

   assign drv_en_o = {BYTES{act_out}} & ~mask_d;
   assign vld_o    = act_out & ~(&mask_d);

   generate
      for (genvar b = 0; b < BYTES; b++) begin : g_byte
         assign dq_o[8*b +: 8] = drv_en_o[b] ? data_out[8*b +: 8] : 8'h00;
      end
   endgenerate

   AST_LAT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(lat_q)); // R9
   AST_LAT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(lat_q) >= 1) && (int'(lat_q) <= MAX_LAT)); // R9
   AST_VLD_DRV: assert property (@(posedge clk) disable iff (!rst_n)
      vld_o == (drv_en_o != '0)); // R6

   generate
      if (MASK_LAT == 2) begin : g_mask_chk
         logic [1:0] age_q;
         always_ff @(posedge clk) begin
            if (!rst_n) age_q <= '0;
            else if (age_q != 2'd3) age_q <= age_q + 2'd1;
         end
         AST_MASK_LAT: assert property (@(posedge clk) disable iff (!rst_n)
            (age_q >= 2'd2 && act_out) |-> (drv_en_o == ~$past(rmask_i, 2))); // R5
      end
   endgenerate
endmodule

// File: tb/sdram_rdlat_pipe_test.sv
`timescale 1ns/1ps
module sdram_rdlat_pipe_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rd_issue_i = 1'b0, stop_i = 1'b0, pre_i = 1'b0;
   logic [1:0]  lat_cfg_i = 2'd0, rmask_i = 2'd0;
   logic [15:0] arr_data_i = 16'h0;
   logic [15:0] dq_o;
   logic [1:0]  drv_en_o;
   logic        vld_o;

   int checks = 0, errors = 0, cyc = 0;
   bit done = 0;

   // model state
   int rem_m = 0, pc_m = 0, lat_m = 2;
   bit        h_act [16];
   bit [15:0] h_dat [16];
   bit [1:0]  h_msk [16];

   always #2.5 clk = ~clk;

   sdram_rdlat_pipe uut (
      .clk(clk), .rst_n(rst_n), .rd_issue_i(rd_issue_i), .lat_cfg_i(lat_cfg_i),
      .rmask_i(rmask_i), .stop_i(stop_i), .pre_i(pre_i), .arr_data_i(arr_data_i),
      .dq_o(dq_o), .drv_en_o(drv_en_o), .vld_o(vld_o));

   task automatic compare(input string tag);
      bit        a;
      bit [15:0] d, edq;
      bit [1:0]  m, en;
      bit        ev;
      a = (cyc - lat_m >= 0) ? h_act[(cyc - lat_m) % 16] : 1'b0;
      d = (cyc - lat_m >= 0) ? h_dat[(cyc - lat_m) % 16] : 16'h0;
      m = (cyc - 2 >= 0) ? h_msk[(cyc - 2) % 16] : 2'b00;
      en  = a ? (~m & 2'b11) : 2'b00;
      edq = {en[1] ? d[15:8] : 8'h00, en[0] ? d[7:0] : 8'h00};
      ev  = (en != 2'b00);
      checks++;
      if (dq_o !== edq || drv_en_o !== en || vld_o !== ev) begin
         errors++;
         $display("FAIL %s cycle %0d: dq=%h en=%b vld=%b expected dq=%h en=%b vld=%b",
                  tag, cyc, dq_o, drv_en_o, vld_o, edq, en, ev);
      end
   endtask

   // one cycle: check current outputs, drive inputs, advance model
   task automatic step(input bit rd, input bit stp, input bit pre, input bit [1:0] msk,
                       input bit [1:0] cfg, input string tag);
      bit busy, kill, act;
      bit [15:0] dat;
      compare(tag);
      dat = {cyc[7:0] ^ 8'h5A, cyc[7:0] + 8'h11};
      rd_issue_i = rd; stop_i = stp; pre_i = pre; rmask_i = msk; lat_cfg_i = cfg;
      arr_data_i = dat;
      busy = (rem_m != 0) || (pc_m != 0);
      for (int k = 1; k <= 3; k++)
         if (cyc - k >= 0 && h_act[(cyc - k) % 16]) busy = 1;
      kill = stp || (pre && lat_m == 3) || (pc_m == 1);
      act  = (rd || rem_m != 0) && !kill;
      h_act[cyc % 16] = act;
      h_dat[cyc % 16] = dat;
      h_msk[cyc % 16] = msk;
      if (kill) rem_m = 0;
      else if (rd) rem_m = 3;
      else if (rem_m != 0) rem_m--;
      if (pre && lat_m < 3) pc_m = 3 - lat_m;
      else if (pc_m != 0) pc_m--;
      if (!busy && cfg >= 1 && cfg <= 3) lat_m = cfg;
      cyc++;
      @(negedge clk);
   endtask

   task automatic idle(input int n, input bit [1:0] cfg, input string tag);
      for (int i = 0; i < n; i++) step(0, 0, 0, 2'b00, cfg, tag);
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run did not end, expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state and default latency of 2, cfg 0 ignored
      idle(2, 2'd0, "R1");
      step(1, 0, 0, 2'b00, 2'd0, "R1");
      idle(8, 2'd0, "R1");
      // R2/R3: latency 1 and 3, full bursts
      idle(2, 2'd1, "R2");
      step(1, 0, 0, 2'b00, 2'd1, "R2");
      idle(8, 2'd1, "R3");
      idle(2, 2'd3, "R2");
      step(1, 0, 0, 2'b00, 2'd3, "R2");
      idle(8, 2'd3, "R3");
      // R9: request made while busy then withdrawn is never applied
      step(1, 0, 0, 2'b00, 2'd3, "R9");
      idle(5, 2'd1, "R9");
      idle(4, 2'd3, "R9");
      idle(3, 2'd0, "R9");
      step(1, 0, 0, 2'b00, 2'd0, "R9");
      idle(8, 2'd0, "R9");
      // R4: interrupts at each latency
      for (int l = 1; l <= 3; l++) begin
         idle(2, 2'(l), "R4");
         step(1, 0, 0, 2'b00, 2'(l), "R4");
         step(0, 0, 0, 2'b00, 2'(l), "R4");
         step(1, 0, 0, 2'b00, 2'(l), "R4");
         step(1, 0, 0, 2'b00, 2'(l), "R4");
         idle(9, 2'(l), "R4");
      end
      // R5/R6: mask patterns during bursts
      for (int l = 1; l <= 3; l++) begin
         idle(2, 2'(l), "R5");
         step(1, 0, 0, 2'b01, 2'(l), "R5");
         step(0, 0, 0, 2'b10, 2'(l), "R5");
         step(0, 0, 0, 2'b11, 2'(l), "R6");
         step(0, 0, 0, 2'b00, 2'(l), "R6");
         step(0, 0, 0, 2'b11, 2'(l), "R6");
         step(0, 0, 0, 2'b01, 2'(l), "R5");
         idle(6, 2'(l), "R5");
      end
      // R7: burst stop mid-burst and with a read
      for (int l = 1; l <= 3; l++) begin
         idle(2, 2'(l), "R7");
         step(1, 0, 0, 2'b00, 2'(l), "R7");
         step(0, 1, 0, 2'b00, 2'(l), "R7");
         idle(6, 2'(l), "R7");
         step(1, 1, 0, 2'b00, 2'(l), "R7");
         idle(6, 2'(l), "R7");
      end
      // R8: precharge mid-burst and with a read
      for (int l = 1; l <= 3; l++) begin
         idle(2, 2'(l), "R8");
         step(1, 0, 0, 2'b00, 2'(l), "R8");
         step(0, 0, 1, 2'b00, 2'(l), "R8");
         idle(7, 2'(l), "R8");
         step(1, 0, 1, 2'b00, 2'(l), "R8");
         idle(7, 2'(l), "R8");
      end
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule